// File: doc/BRIEF.md
# Clause-45 MDIO Management Sequencer

This block lets a host reach the registers of an external 10G PHY over a two-wire Clause-45 management bus. The host sees two 32-bit registers: a command register and a data register. A command word names a port, a device inside that port, a 16-bit register address and an opcode. Setting the go bit in the same write launches one serial frame on MDC/MDIO. The go bit then reads back as busy until the frame has left the wire.

Every PHY access is a pair of frames. First the host issues an address frame carrying the register address and polls until busy drops. Then it issues a write frame or a read frame for the same port and device. Before a write, the host loads the 16-bit value into the low half of the data register. After a read completes, the value returned by the PHY sits in the high half of that register.

MDC comes from the system clock through a parameterised divider and stays low between frames. The sequencer changes MDIO after each falling edge of MDC and samples the returning line on rising edges. It releases the line for the turnaround and the data field of read-type frames.

Top module: `mdio_c45_sequencer`

## Requirements
- R1: The command register reads back as follows: bits [15:0] hold the register address, [20:16] the device, [25:21] the port and [27:26] the opcode. Bit 30 is go/busy, and bits 31, 29 and 28 read as 0. The host selects the command register with host_sel=0 and the data register with host_sel=1.
- R2: A command write with bit 30 set, made while idle, starts a frame. Bit 30 reads 1 from the cycle after the write until the frame ends, and then reads 0.
- R3: A frame is PRE_LEN ones, then the start bits 00, then the 2-bit opcode, the 5-bit port and the 5-bit device, then the turnaround, then 16 payload bits. Every field is sent MSB first, and each bit is stable across a rising edge of MDC. Non-read frames carry the turnaround 10, and the output is enabled for all of their bits.
- R4: Opcode 00 (address) sends the register-address field as payload. Opcode 01 (write) sends data register bits [15:0].
- R5: For opcodes with bit 1 set (11 read, 10 read with increment), the output enable is 0 from the first turnaround bit through the last payload bit. The input is sampled on the 16 rising edges of the payload field, MSB first. At completion the sample lands in data register bits [31:16].
- R6: A data-register write stores host bits [15:0] and leaves bits [31:16] alone. Frames with opcode bit 1 clear do not change bits [31:16].
- R7: While busy, writes to either register are ignored: the fields, the low data half and the frame count stay as they were.
- R8: MDC has a period of 2*CLK_DIV clocks while busy and is low when idle. The output enable is 0 when idle.
- R9: After reset both registers read 0, MDC is low and the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | 0 selects the command register, 1 the data register |
| host_wdata | input | 32 | Host write data |
| cmd_rd | output | 32 | Command register readback, bit 30 is busy |
| data_rd | output | 32 | Data register, read result in [31:16] |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data to the pad driver |
| mdio_oe | output | 1 | Pad driver enable, 0 releases the line |
| mdio_i | input | 1 | Serial data from the pad |

## Verification
The assertions assume that host_wr is a single-cycle strobe sampled at the clock edge. They also assume that mdio_i holds a defined level at every rising edge of MDC inside the payload of a read frame. The bench keeps to both assumptions. It drives all host writes from tasks at the falling clock edge and keeps each strobe one cycle wide. A PHY model answers every read: it holds the line high outside the payload and presents each returned bit from the rising edge before the one on which it is sampled.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
   localparam int HOST_W   = 32;
   localparam int REG_W    = 16;
   localparam int PORT_W   = 5;
   localparam int DEV_W    = 5;
   localparam int REG_LSB  = 0;
   localparam int DEV_LSB  = 16;
   localparam int PORT_LSB = 21;
   localparam int OP_LSB   = 26;
   localparam int GO_BIT   = 30;
   localparam int HDR_BITS = 32;

   typedef enum logic [1:0] {
      OP_ADDR  = 2'b00,
      OP_WRITE = 2'b01,
      OP_RDINC = 2'b10,
      OP_READ  = 2'b11
   } mdio_op_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tk,
   output logic fall_tk
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin
      assert (DIV >= 1) else $error("DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mdc <= 1'b0;
            else if (!run) mdc <= 1'b0;
            else          mdc <= ~mdc;
         end
         assign rise_tk = run && !mdc;
         assign fall_tk = run && mdc;
      end else begin : g_cnt
         localparam logic [CW-1:0] TOP = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
               mdc <= 1'b0;
            end else if (!run) begin
               cnt <= '0;
               mdc <= 1'b0;
            end else if (cnt == TOP) begin
               cnt <= '0;
               mdc <= ~mdc;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign rise_tk = run && (cnt == TOP) && !mdc;
         assign fall_tk = run && (cnt == TOP) && mdc;

         // R8: MDC only moves at the end of a divider period
         a_r8_mdc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(mdc) && $past(run)) |-> $past(cnt == TOP));
      end
   endgenerate

   // R8: MDC rests low while no frame runs
   a_r8_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_c45_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [DEV_W-1:0]  dev_i,
   input  logic [REG_W-1:0]  payload_i,
   input  logic              rise_tk,
   input  logic              fall_tk,
   input  logic              sdi,
   output logic              active,
   output logic              done,
   output logic              sdo,
   output logic              sdo_en,
   output logic [REG_W-1:0]  rd_word
);
   localparam int FRAME_LEN = PRE_LEN + HDR_BITS;
   localparam int IW        = $clog2(FRAME_LEN);
   localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);
   localparam logic [IW-1:0] TA_IDX   = IW'(PRE_LEN + 14);
   localparam logic [IW-1:0] DATA_IDX = IW'(PRE_LEN + 16);
   localparam logic [IW-1:0] PRE_END  = IW'(PRE_LEN);

   initial begin
      assert (PRE_LEN >= 1) else $error("PRE_LEN must be at least 1");
   end

   logic [FRAME_LEN-1:0] sreg;
   logic [IW-1:0]        idx;
   logic                 rd_type;
   logic [1:0]           ta_bits;

   assign ta_bits = op_i[1] ? 2'b00 : 2'b10;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg    <= '0;
         idx     <= '0;
         active  <= 1'b0;
         rd_type <= 1'b0;
      end else if (start && !active) begin
         sreg    <= {{PRE_LEN{1'b1}}, 2'b00, op_i, port_i, dev_i, ta_bits, payload_i};
         idx     <= '0;
         active  <= 1'b1;
         rd_type <= op_i[1];
      end else if (active && fall_tk) begin
         if (idx == LAST_IDX) begin
            active <= 1'b0;
         end else begin
            idx  <= idx + 1'b1;
            sreg <= sreg << 1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_word <= '0;
      else if (active && rd_type && rise_tk && (idx >= DATA_IDX))
         rd_word <= {rd_word[REG_W-2:0], sdi};
   end

   assign done   = active && fall_tk && (idx == LAST_IDX);
   assign sdo    = active ? sreg[FRAME_LEN-1] : 1'b1;
   assign sdo_en = active && !(rd_type && (idx >= TA_IDX));

   // R3: the preamble drives ones onto an enabled line
   a_r3_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (idx < PRE_END)) |-> (sdo && sdo_en));

   // R3: a frame advances one bit per MDC period, never skipping
   a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$stable(idx)) |-> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/mdio_c45_sequencer.sv
module mdio_c45_sequencer
   import mdio_c45_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_sel,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] cmd_rd,
   output logic [HOST_W-1:0] data_rd,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   logic [REG_W-1:0]  reg_q;
   logic [DEV_W-1:0]  dev_q;
   logic [PORT_W-1:0] port_q;
   logic [1:0]        op_q;
   logic [REG_W-1:0]  data_lo;
   logic [REG_W-1:0]  data_hi;

   logic busy, done, rise_tk, fall_tk;
   logic [REG_W-1:0] rd_word;

   logic              cmd_take, data_take, go;
   logic [1:0]        op_new;
   logic [REG_W-1:0]  reg_new;
   logic [REG_W-1:0]  payload;
   logic              unused_bits;

   assign cmd_take  = host_wr && !host_sel && !busy;
   assign data_take = host_wr && host_sel && !busy;
   assign go        = host_wdata[GO_BIT];
   assign op_new    = host_wdata[OP_LSB +: 2];
   assign reg_new   = host_wdata[REG_LSB +: REG_W];
   assign payload   = (op_new == OP_ADDR) ? reg_new : data_lo;
   assign unused_bits = ^{host_wdata[31], host_wdata[29:28]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q  <= '0;
         dev_q  <= '0;
         port_q <= '0;
         op_q   <= '0;
      end else if (cmd_take) begin
         reg_q  <= reg_new;
         dev_q  <= host_wdata[DEV_LSB +: DEV_W];
         port_q <= host_wdata[PORT_LSB +: PORT_W];
         op_q   <= op_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_lo <= '0;
         data_hi <= '0;
      end else begin
         if (data_take)
            data_lo <= host_wdata[REG_W-1:0];
         if (done && op_q[1])
            data_hi <= rd_word;
      end
   end

   mdio_clk_div #(.DIV(CLK_DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .mdc     (mdc),
      .rise_tk (rise_tk),
      .fall_tk (fall_tk)
   );

   mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_take && go),
      .op_i      (op_new),
      .port_i    (host_wdata[PORT_LSB +: PORT_W]),
      .dev_i     (host_wdata[DEV_LSB +: DEV_W]),
      .payload_i (payload),
      .rise_tk   (rise_tk),
      .fall_tk   (fall_tk),
      .sdi       (mdio_i),
      .active    (busy),
      .done      (done),
      .sdo       (mdio_o),
      .sdo_en    (mdio_oe),
      .rd_word   (rd_word)
   );

   assign cmd_rd  = {1'b0, busy, 2'b00, op_q, port_q, dev_q, reg_q};
   assign data_rd = {data_hi, data_lo};

   // R7: command fields hold across any cycle spent busy
   a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_rd[29:0]));

   // R7: low data half holds while busy
   a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(data_rd[15:0]));

   // R2: busy drops only at the end of the last frame bit
   a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   // R6: read half changes only when a read-type frame completes
   a_r6_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_rd[31:16]) |-> $past(done && op_q[1]));

   // R8: driver released whenever idle
   a_r8_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_c45_sequencer.sv
module tb_mdio_c45_sequencer;
   localparam int CLK_DIV = 2;
   localparam int PRE_LEN = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] cmd_rd, data_rd;
   logic        mdc, mdio_o, mdio_oe, mdio_i;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mdio_c45_sequencer #(.CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN)) dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .cmd_rd(cmd_rd), .data_rd(data_rd),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: records each bit at MDC rising edges, returns read data
   int          bitcnt = 0;
   logic [63:0] rx_bits = '0;
   logic [63:0] rx_oe = '0;
   logic [15:0] phy_val = '0;
   realtime     t_rise_prev = 0, t_rise_last = 0;

   always @(posedge mdc) begin
      rx_bits = {rx_bits[62:0], mdio_o};
      rx_oe   = {rx_oe[62:0], mdio_oe};
      bitcnt  = bitcnt + 1;
      t_rise_prev = t_rise_last;
      t_rise_last = $realtime;
   end

   function automatic logic phy_bit(int k);
      if (k >= 48 && k < 64) return phy_val[63 - k];
      return 1'b1;
   endfunction

   assign mdio_i = phy_bit(bitcnt);

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(logic sel, logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         if (!cmd_rd[30]) return;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] cmd_word(logic go, logic [1:0] op, logic [4:0] port,
                                            logic [4:0] dev, logic [15:0] ra);
      return {1'b0, go, 2'b00, op, port, dev, ra};
   endfunction

   function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] port,
                                             logic [4:0] dev, logic [15:0] pl);
      return {32'hFFFF_FFFF, 2'b00, op, port, dev, (op[1] ? 2'b00 : 2'b10), pl};
   endfunction

   // one frame; checks busy rises next cycle (R2) and the bit count (R3)
   task automatic run_frame(logic [1:0] op, logic [4:0] port, logic [4:0] dev, logic [15:0] ra);
      bitcnt = 0;
      host_write(1'b0, cmd_word(1'b1, op, port, dev, ra));
      chk("R2 busy set after go", {63'd0, cmd_rd[30]}, 64'd1);
      wait_idle();
      chk("R2 busy cleared at end", {63'd0, cmd_rd[30]}, 64'd0);
      chk("R3 bit count", 64'(bitcnt), 64'd64);
   endtask

   // {op, port, dev, reg, wdata, phy}
   localparam int NV = 6;
   localparam logic [59:0] VEC [NV] = '{
      {2'b01, 5'h01, 5'h01, 16'h0000, 16'hA5A5, 16'h0000},
      {2'b11, 5'h1F, 5'h03, 16'hC803, 16'h0000, 16'h1234},
      {2'b01, 5'h00, 5'h1E, 16'hFFFF, 16'h0164, 16'h0000},
      {2'b11, 5'h0A, 5'h07, 16'h0001, 16'h0000, 16'hFFFF},
      {2'b10, 5'h15, 5'h0A, 16'h8000, 16'h0000, 16'h8001},
      {2'b11, 5'h00, 5'h00, 16'h0000, 16'h0000, 16'h0000}
   };

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] hi_exp;
      logic [15:0] lo_exp;
      hi_exp = '0;
      lo_exp = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 cmd reset", 64'(cmd_rd), 64'd0);
      chk("R9 data reset", 64'(data_rd), 64'd0);
      chk("R9 mdc/oe reset", {62'd0, mdc, mdio_oe}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [1:0]  op;
         logic [4:0]  port, dev;
         logic [15:0] ra, wd, pv;
         {op, port, dev, ra, wd, pv} = VEC[v];
         phy_val = pv;
         if (!op[1]) begin
            host_write(1'b1, {16'hFFFF, wd});
            lo_exp = wd;
         end
         // address frame (R4)
         run_frame(2'b00, port, dev, ra);
         chk("R4 address frame bits", rx_bits, exp_frame(2'b00, port, dev, ra));
         chk("R3 address frame oe", rx_oe, 64'hFFFF_FFFF_FFFF_FFFF);
         chk("R8 idle oe/mdc", {62'd0, mdc, mdio_oe}, 64'd0);
         // data frame
         run_frame(op, port, dev, ra);
         if (op[1]) begin
            hi_exp = pv;
            chk("R5 read header bits", {18'd0, rx_bits[63:18]},
                {18'd0, exp_frame(op, port, dev, 16'h0)} >> 18);
            chk("R5 read release", rx_oe, 64'hFFFF_FFFF_FFFC_0000);
            chk("R5 read data high half", 64'(data_rd[31:16]), 64'(hi_exp));
         end else begin
            chk("R4 write frame bits", rx_bits, exp_frame(op, port, dev, wd));
            chk("R3 write frame oe", rx_oe, 64'hFFFF_FFFF_FFFF_FFFF);
            chk("R6 write keeps high half", 64'(data_rd[31:16]), 64'(hi_exp));
         end
         chk("R6 low half", 64'(data_rd[15:0]), 64'(lo_exp));
         chk("R1 command readback", 64'(cmd_rd), 64'(cmd_word(1'b0, op, port, dev, ra)));
      end

      // R8 MDC period: 2*CLK_DIV clocks of 8 ns
      chk("R8 mdc period ns", 64'(int'(t_rise_last - t_rise_prev)), 64'(2 * CLK_DIV * 8));

      // R6 data write ignores upper host bits
      host_write(1'b1, 32'hDEAD_5555);
      lo_exp = 16'h5555;
      chk("R6 data write low", 64'(data_rd), 64'({hi_exp, lo_exp}));

      // R7 writes while busy are ignored
      bitcnt = 0;
      host_write(1'b0, cmd_word(1'b1, 2'b01, 5'h03, 5'h04, 16'h0042));
      host_write(1'b0, cmd_word(1'b1, 2'b11, 5'h1F, 5'h1F, 16'hFFFF));
      host_write(1'b1, 32'h0000_AAAA);
      wait_idle();
      chk("R7 cmd unchanged", 64'(cmd_rd), 64'(cmd_word(1'b0, 2'b01, 5'h03, 5'h04, 16'h0042)));
      chk("R7 data unchanged", 64'(data_rd), 64'({hi_exp, lo_exp}));
      repeat (300) @(negedge clk);
      chk("R7 no second frame", 64'(bitcnt), 64'd64);
      chk("R7 frame used old data", rx_bits, exp_frame(2'b01, 5'h03, 5'h04, 16'h5555));

      // R1 command write without go stores fields, starts nothing
      bitcnt = 0;
      host_write(1'b0, 32'hFFFF_FFFF & ~32'h4000_0000);
      repeat (40) @(negedge clk);
      chk("R1 no-go write readback", 64'(cmd_rd), 64'h0FFF_FFFF);
      chk("R2 no-go no frame", 64'(bitcnt), 64'd0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule